// File: doc/BRIEF.md
# Codec Register Access Slot Formatter

This controller-side block turns one register read or write request into the three command words of an outgoing serial audio link frame. These are the tag word, the command-address slot and the command-data slot. It then collects the status reply that the codec returns during the following frame. It works on parallel slot words and a frame strobe. The serial shifter, the audio sample slots and the link reset sequence sit outside it.

A request can target the primary codec (codec ID 0) or one of three secondary codecs (IDs 1 to 3), and the two kinds are tagged differently. Only one access is in flight at a time. The requester sees a valid/ready handshake on the request side and a one-cycle response pulse that carries the read data or an error flag. The frame strobe is a single-cycle pulse at each frame boundary. On that pulse the block loads the outgoing words for the frame that is starting and samples the incoming slots of the frame that has just ended.

Top module: `codec_reg_slot_fmt`

## Requirements
- R1: After reset, and whenever no access is in flight, `reqReady` is 1 and `outTag` is 16'h8000 (bit 15 set, all other bits 0). Both command slots are 0, and `rspValid` stays 0 across frame strobes when nothing was requested.
- R2: For a primary read (codec 0, `reqWrite`=0), `outTag` is 16'hC000 during the command frame: bits 15 and 14 set, bit 13 clear, ID bits 1:0 = 00.
- R3: For a primary write (codec 0, `reqWrite`=1), `outTag` is 16'hE000 during the command frame: bits 15, 14 and 13 set, ID bits = 00.
- R4: For a secondary access (codec 1, 2 or 3, read or write), `outTag` during the command frame is 16'h8000 with the codec number in bits 1:0, and bits 14 and 13 are 0.
- R5: During the command frame, `outCmdAddr` carries 1 in bit 19 for a read and 0 for a write, the 7-bit register address in bits 18:12, and zeros in bits 11:0.
- R6: During the command frame, `outCmdData` carries the 16-bit write data in bits 19:4 with bits 3:0 zero for a write, for any codec. For a read it is 0.
- R7: The command words appear on the frame strobe after the request is accepted. They last exactly one frame, and on the next strobe the slots return to the idle values of R1.
- R8: A request is accepted on a cycle with `reqValid` and `reqReady` both 1. `reqReady` then stays 0 until the response pulse. Requests presented while it is 0 are not taken, and changes to the request inputs after acceptance do not alter the command that is sent.
- R9: For a read, the status is sampled on the strobe that ends the frame after the command frame. The status is valid when `inTag` bits 15:13 are 111, `inTag` bits 1:0 are 00, `inStatAddr` bits 18:12 equal the requested address, `inStatAddr` bits 11:0 are 0 and `inStatData` bits 3:0 are 0. A valid status gives `rspValid` high for one cycle after that strobe, with `rspError`=0 and `rspData` = `inStatData` bits 19:4.
- R10: A read whose status breaks any condition of R9 still gives the one-cycle `rspValid`, with `rspError`=1 and `rspData`=0.
- R11: A write completes at that same strobe, one frame after its command frame. It gives the one-cycle `rspValid` with `rspError`=0 and `rspData`=0, and the incoming slots are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameStrobe | input | 1 | One-cycle pulse at each frame boundary |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqCodec | input | 2 | Target codec ID, 0 = primary |
| reqAddr | input | 7 | Register address |
| reqData | input | 16 | Write data |
| outTag | output | 16 | Outgoing tag word |
| outCmdAddr | output | 20 | Outgoing command-address slot |
| outCmdData | output | 20 | Outgoing command-data slot |
| inTag | input | 16 | Incoming tag word of the frame ending at the strobe |
| inStatAddr | input | 20 | Incoming status-address slot |
| inStatData | input | 20 | Incoming status-data slot |
| rspValid | output | 1 | One-cycle completion pulse |
| rspError | output | 1 | Read status missing or mismatched |
| rspData | output | 16 | Read data, 0 on error or for writes |

## Verification
The hardest case to reach from the ports is a read whose reply arrives on time but is wrong in only one respect: a missing tag bit, a non-zero ID, or an address echo that is off by a single bit. The stimulus would otherwise look like a good reply. The bench plays the codec side frame by frame. It sweeps every codec ID against both directions and several addresses, and it corrupts the reply slots in chosen ways on the exact frame the block samples. It also holds a conflicting request on the inputs for the whole time an access is busy, so that a wrongly accepted or re-latched request shows up in the command words.

// File: rtl/codec_slot_pkg.sv
package codec_slot_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PEND = 2'd1,
    ST_SENT = 2'd2,
    ST_WAIT = 2'd3
  } slot_state_t;

  typedef struct packed {
    logic latchReq;
    logic sendCmd;
    logic clearCmd;
    logic finish;
  } slot_ctrl_t;

endpackage

// File: rtl/codec_slot_ctrl.sv
module codec_slot_ctrl
  import codec_slot_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       frameStrobe,
  input  logic       reqValid,
  output logic       reqReady,
  output slot_ctrl_t ctl
);

  slot_state_t state, nextState;

  always_comb begin
    nextState = state;
    ctl = '0;
    unique case (state)
      ST_IDLE: if (reqValid) begin
        ctl.latchReq = 1'b1;
        nextState = ST_PEND;
      end
      ST_PEND: if (frameStrobe) begin
        ctl.sendCmd = 1'b1;
        nextState = ST_SENT;
      end
      ST_SENT: if (frameStrobe) begin
        ctl.clearCmd = 1'b1;
        nextState = ST_WAIT;
      end
      ST_WAIT: if (frameStrobe) begin
        ctl.finish = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign reqReady = (state == ST_IDLE);

endmodule

// File: rtl/codec_slot_dpath.sv
module codec_slot_dpath
  import codec_slot_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16,
  parameter int SLOT_W = 20,
  parameter int TAG_W  = 16,
  parameter int ID_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  slot_ctrl_t        ctl,
  input  logic              reqWrite,
  input  logic [ID_W-1:0]   reqCodec,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic [TAG_W-1:0]  outTag,
  output logic [SLOT_W-1:0] outCmdAddr,
  output logic [SLOT_W-1:0] outCmdData,
  input  logic [TAG_W-1:0]  inTag,
  input  logic [SLOT_W-1:0] inStatAddr,
  input  logic [SLOT_W-1:0] inStatData,
  output logic              rspValid,
  output logic              rspError,
  output logic [DATA_W-1:0] rspData
);

  localparam int BIT_FRAME = TAG_W - 1;
  localparam int BIT_ADDRV = TAG_W - 2;
  localparam int BIT_DATAV = TAG_W - 3;
  localparam int BIT_RD    = SLOT_W - 1;
  localparam int ADDR_LSB  = SLOT_W - 1 - ADDR_W;
  localparam int DATA_LSB  = SLOT_W - DATA_W;
  localparam logic [TAG_W-1:0] IDLE_TAG = TAG_W'(1) << BIT_FRAME;

  logic              holdWrite;
  logic [ID_W-1:0]   holdCodec;
  logic [ADDR_W-1:0] holdAddr;
  logic [DATA_W-1:0] holdData;

  logic [TAG_W-1:0]  cmdTag;
  logic [SLOT_W-1:0] cmdAddrWord;
  logic [SLOT_W-1:0] cmdDataWord;
  logic              statusOk;

  always_comb begin
    cmdTag = IDLE_TAG;
    if (holdCodec == '0) begin
      cmdTag[BIT_ADDRV] = 1'b1;
      cmdTag[BIT_DATAV] = holdWrite;
    end else begin
      cmdTag[ID_W-1:0] = holdCodec;
    end
  end

  always_comb begin
    cmdAddrWord = '0;
    cmdAddrWord[BIT_RD] = ~holdWrite;
    cmdAddrWord[ADDR_LSB +: ADDR_W] = holdAddr;
    cmdDataWord = '0;
    if (holdWrite) cmdDataWord[DATA_LSB +: DATA_W] = holdData;
  end

  assign statusOk = inTag[BIT_FRAME] && inTag[BIT_ADDRV] && inTag[BIT_DATAV]
                 && (inTag[ID_W-1:0] == '0)
                 && (inStatAddr[ADDR_LSB +: ADDR_W] == holdAddr)
                 && (inStatAddr[ADDR_LSB-1:0] == '0)
                 && (inStatData[DATA_LSB-1:0] == '0);

  logic unusedInBits;
  assign unusedInBits = ^{inTag[BIT_DATAV-1:ID_W], inStatAddr[BIT_RD]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdWrite  <= 1'b0;
      holdCodec  <= '0;
      holdAddr   <= '0;
      holdData   <= '0;
      outTag     <= IDLE_TAG;
      outCmdAddr <= '0;
      outCmdData <= '0;
      rspValid   <= 1'b0;
      rspError   <= 1'b0;
      rspData    <= '0;
    end else begin
      rspValid <= ctl.finish;
      if (ctl.latchReq) begin
        holdWrite <= reqWrite;
        holdCodec <= reqCodec;
        holdAddr  <= reqAddr;
        holdData  <= reqData;
      end
      if (ctl.sendCmd) begin
        outTag     <= cmdTag;
        outCmdAddr <= cmdAddrWord;
        outCmdData <= cmdDataWord;
      end else if (ctl.clearCmd) begin
        outTag     <= IDLE_TAG;
        outCmdAddr <= '0;
        outCmdData <= '0;
      end
      if (ctl.finish) begin
        rspError <= !holdWrite && !statusOk;
        rspData  <= (!holdWrite && statusOk) ? inStatData[DATA_LSB +: DATA_W] : '0;
      end
    end
  end

endmodule

// File: rtl/codec_reg_slot_fmt.sv
module codec_reg_slot_fmt
  import codec_slot_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16,
  parameter int SLOT_W = 20,
  parameter int TAG_W  = 16,
  parameter int ID_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStrobe,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ID_W-1:0]   reqCodec,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic [TAG_W-1:0]  outTag,
  output logic [SLOT_W-1:0] outCmdAddr,
  output logic [SLOT_W-1:0] outCmdData,
  input  logic [TAG_W-1:0]  inTag,
  input  logic [SLOT_W-1:0] inStatAddr,
  input  logic [SLOT_W-1:0] inStatData,
  output logic              rspValid,
  output logic              rspError,
  output logic [DATA_W-1:0] rspData
);

  slot_ctrl_t ctl;

  codec_slot_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameStrobe(frameStrobe),
    .reqValid(reqValid), .reqReady(reqReady), .ctl(ctl)
  );

  codec_slot_dpath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W), .TAG_W(TAG_W), .ID_W(ID_W)
  ) u_dpath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .reqWrite(reqWrite), .reqCodec(reqCodec), .reqAddr(reqAddr), .reqData(reqData),
    .outTag(outTag), .outCmdAddr(outCmdAddr), .outCmdData(outCmdData),
    .inTag(inTag), .inStatAddr(inStatAddr), .inStatData(inStatData),
    .rspValid(rspValid), .rspError(rspError), .rspData(rspData)
  );

endmodule

// File: rtl/codec_slot_checker.sv
module codec_slot_checker #(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 16,
  parameter int SLOT_W = 20,
  parameter int TAG_W  = 16,
  parameter int ID_W   = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameStrobe,
  input logic              reqValid,
  input logic              reqReady,
  input logic [TAG_W-1:0]  outTag,
  input logic [SLOT_W-1:0] outCmdAddr,
  input logic [SLOT_W-1:0] outCmdData,
  input logic              rspValid,
  input logic              rspError,
  input logic [DATA_W-1:0] rspData
);

  p_frame_bit_r1: assert property (@(posedge clk) disable iff (!rstN)
    outTag[TAG_W-1]);

  p_idle_slots_r1: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (outTag[TAG_W-2:TAG_W-3] == 2'b00 && outCmdAddr == '0 && outCmdData == '0));

  p_sec_tags_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outTag[ID_W-1:0] != '0) |-> (outTag[TAG_W-2:TAG_W-3] == 2'b00));

  p_one_outstanding_r8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  p_rsp_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  p_rsp_after_strobe_r11: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> $past(frameStrobe));

  p_err_no_data_r10: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspError) |-> (rspData == '0));

endmodule

bind codec_reg_slot_fmt codec_slot_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SLOT_W(SLOT_W), .TAG_W(TAG_W), .ID_W(ID_W)
) u_checker (
  .clk(clk), .rstN(rstN), .frameStrobe(frameStrobe), .reqValid(reqValid),
  .reqReady(reqReady), .outTag(outTag), .outCmdAddr(outCmdAddr),
  .outCmdData(outCmdData), .rspValid(rspValid), .rspError(rspError), .rspData(rspData)
);

// File: tb/codec_reg_slot_fmt_test.sv
module codec_reg_slot_fmt_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        frameStrobe = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqCodec = '0;
  logic [6:0]  reqAddr = '0;
  logic [15:0] reqData = '0;
  logic [15:0] outTag;
  logic [19:0] outCmdAddr;
  logic [19:0] outCmdData;
  logic [15:0] inTag = '0;
  logic [19:0] inStatAddr = '0;
  logic [19:0] inStatData = '0;
  logic        rspValid;
  logic        rspError;
  logic [15:0] rspData;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  codec_reg_slot_fmt uut (
    .clk(clk), .rstN(rstN), .frameStrobe(frameStrobe),
    .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqCodec(reqCodec), .reqAddr(reqAddr), .reqData(reqData),
    .outTag(outTag), .outCmdAddr(outCmdAddr), .outCmdData(outCmdData),
    .inTag(inTag), .inStatAddr(inStatAddr), .inStatData(inStatData),
    .rspValid(rspValid), .rspError(rspError), .rspData(rspData)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic strobe();
    frameStrobe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    frameStrobe = 1'b0;
  endtask

  task automatic checkIdle(input string req);
    chk(req, {16'h0, outTag}, 32'h8000);
    chk(req, {12'h0, outCmdAddr}, 32'h0);
    chk(req, {12'h0, outCmdData}, 32'h0);
  endtask

  // mode: 0 good reply, 1 tag bit 13 missing, 2 address off by one bit,
  //       3 non-zero ID in reply tag, 4 reserved address bits set
  task automatic access(input logic wr, input logic [1:0] codec, input logic [6:0] addr,
                        input logic [15:0] data, input int mode);
    logic [15:0] expTag;
    logic [15:0] rdVal;
    rdVal = 16'hA55A ^ {addr, 1'b0, addr, codec[0]};
    expTag = 16'h8000;
    if (codec == 2'd0) expTag = expTag | 16'h4000 | (wr ? 16'h2000 : 16'h0);
    else expTag = expTag | {14'h0, codec};
    @(negedge clk);
    chk("R1 ready before access", {31'h0, reqReady}, 32'h1);
    reqValid = 1'b1; reqWrite = wr; reqCodec = codec; reqAddr = addr; reqData = data;
    @(posedge clk);
    @(negedge clk);
    // R8: keep a different request on the inputs while busy
    reqWrite = ~wr; reqCodec = codec + 2'd1; reqAddr = addr ^ 7'h55; reqData = ~data;
    chk("R8 not ready after accept", {31'h0, reqReady}, 32'h0);
    inTag = 16'h0; inStatAddr = '0; inStatData = '0;
    strobe();
    if (codec == 2'd0) chk(wr ? "R3 primary write tag" : "R2 primary read tag", {16'h0, outTag}, {16'h0, expTag});
    else chk("R4 secondary tag", {16'h0, outTag}, {16'h0, expTag});
    chk("R5 cmd addr slot", {12'h0, outCmdAddr}, {12'h0, {~wr, addr, 12'h000}});
    chk("R6 cmd data slot", {12'h0, outCmdData}, {12'h0, wr ? {data, 4'h0} : 20'h0});
    chk("R8 busy in command frame", {31'h0, reqReady}, 32'h0);
    strobe();
    checkIdle("R7 slots idle after one frame");
    chk("R7 no early response", {31'h0, rspValid}, 32'h0);
    reqValid = 1'b0;
    inTag = 16'hE000;
    inStatAddr = {1'b0, addr, 12'h000};
    inStatData = {rdVal, 4'h0};
    if (mode == 1) inTag = 16'hC000;
    if (mode == 2) inStatAddr = {1'b0, addr ^ 7'h10, 12'h000};
    if (mode == 3) inTag = 16'hE001;
    if (mode == 4) inStatAddr = {1'b0, addr, 12'h008};
    strobe();
    chk("R9 response pulse", {31'h0, rspValid}, 32'h1);
    if (wr) begin
      chk("R11 write no error", {31'h0, rspError}, 32'h0);
      chk("R11 write data zero", {16'h0, rspData}, 32'h0);
    end else if (mode == 0) begin
      chk("R9 read no error", {31'h0, rspError}, 32'h0);
      chk("R9 read data", {16'h0, rspData}, {16'h0, rdVal});
    end else begin
      chk("R10 read error flagged", {31'h0, rspError}, 32'h1);
      chk("R10 no stale data", {16'h0, rspData}, 32'h0);
    end
    chk("R8 ready after response", {31'h0, reqReady}, 32'h1);
    inTag = 16'h0; inStatAddr = '0; inStatData = '0;
    @(negedge clk);
    chk("R9 pulse one cycle", {31'h0, rspValid}, 32'h0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    logic [6:0] addrs [4];
    addrs[0] = 7'h00; addrs[1] = 7'h02; addrs[2] = 7'h7F; addrs[3] = 7'h26;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkIdle("R1 reset slots");
    chk("R1 reset ready", {31'h0, reqReady}, 32'h1);
    chk("R1 reset no response", {31'h0, rspValid}, 32'h0);
    for (int f = 0; f < 3; f++) begin
      strobe();
      checkIdle("R1 idle frame slots");
      chk("R1 idle frame no response", {31'h0, rspValid}, 32'h0);
    end
    for (int c = 0; c < 4; c++)
      for (int w = 0; w < 2; w++)
        for (int a = 0; a < 4; a++)
          access(w[0], c[1:0], addrs[a], 16'h1234 ^ {addrs[a], 1'b1, c[1:0], 6'h2A}, 0);
    for (int m = 1; m < 5; m++) begin
      access(1'b0, 2'd0, 7'h1C, 16'h0, m);
      access(1'b0, 2'd3, 7'h3A, 16'h0, m);
    end
    access(1'b1, 2'd2, 7'h18, 16'hBEEF, 1);
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule